// File: doc/BRIEF.md
# Page Write Buffer and Word Address Counter

This block is the storage side of a small serial EEPROM model. It owns the word address counter, a one-page staging buffer and the byte array. A protocol front end, which is not part of this block, hands it four kinds of strobe:
- a new word address;
- a received data byte;
- a request to step to the next byte after a read transfer;
- the end-of-transaction (STOP) event.

Data bytes collect in the staging buffer at the counter's position within the current page. Only the low page-offset bits of the counter advance, so writing past the end of a page wraps to its start and overwrites earlier bytes. Read steps advance the whole counter, which rolls over at the top of the array. At STOP the received bytes of the page are committed together. A busy flag then stays high for a programmable number of clock ticks, which stand for the self-timed programming cycle. While busy is high, every strobe is ignored.

A write-protect input blocks commits. At densities below 2048 bytes it protects the whole array. At 2048 bytes and above it protects only the upper half. A blocked write still updates the counter as usual, but the array is left unchanged and busy does not rise.

Top module: `eeprom_page_store`

## Requirements
- R1: After reset, the current address is 0, busy is low, and every array byte reads 0.
- R2: An address-load strobe copies the presented address into the counter on the next clock. It also discards any bytes already buffered.
- R3: A data strobe places the byte at the page offset given by the counter's low bits. There are 3 such bits for an 8-byte page (array of 256 bytes or fewer) and 4 bits for a 16-byte page. Only those low bits then increment, wrapping inside the page, so a later byte at the same offset replaces the earlier one.
- R4: Buffered bytes do not reach the array before STOP. At STOP, exactly the received page offsets are written at the current page, and all other bytes keep their contents.
- R5: Busy rises on the clock edge that samples a committing STOP and stays high for exactly WRITE_TICKS cycles.
- R6: While busy is high, address-load, data, read-step and STOP strobes have no effect on the counter, the buffer or the array.
- R7: A read step adds one to the full counter, and the counter rolls over from MEM_BYTES-1 to 0. Between transactions the counter holds the last accessed address plus one.
- R8: With the write-protect input high, a STOP writes nothing and does not raise busy when the page is protected. A page is protected when the array is smaller than 2048 bytes, or when the address MSB is 1 in a 2048-byte array. Low-half pages of a 2048-byte array still commit.
- R9: When several strobes arrive in one cycle, the priority is STOP, then address load, then data, then read step. A STOP with no buffered byte does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wpIn | input | 1 | Write-protect level |
| addrLoad | input | 1 | Load the word address strobe |
| addrIn | input | ADDR_W | Word address to load |
| dataValid | input | 1 | Received write byte strobe |
| dataIn | input | 8 | Received write byte |
| readAdvance | input | 1 | Step counter after a read byte |
| stopSeen | input | 1 | End of transaction strobe |
| curAddr | output | ADDR_W | Current word address |
| readData | output | 8 | Array byte at the current address |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The assertions check the following on every cycle:
- an address load lands in the counter;
- a data byte moves only the in-page offset;
- a read step adds one with wrap;
- the counter is frozen while busy;
- busy starts only after STOP and lasts no longer than the tick count;
- a protected STOP never raises busy.

Only the bench scenarios can show what the array holds. These cover the full-array page sweep, the in-page overwrite order, partial-page preservation and upper-half protection at 2048 bytes.

// File: rtl/eps_pkg.sv
package eps_pkg;
  typedef struct packed {
    logic loadAddr;
    logic storeByte;
    logic advance;
    logic endTxn;
    logic commit;
  } epsStrobe_t;
endpackage

// File: rtl/eps_ctrl.sv
module eps_ctrl
  import eps_pkg::*;
#(
  parameter int WRITE_TICKS = 20,
  parameter bit WHOLE_PROT  = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wpIn,
  input  logic       addrLoad,
  input  logic       dataValid,
  input  logic       readAdvance,
  input  logic       stopSeen,
  input  logic       pageUpper,
  input  logic       pending,
  output epsStrobe_t strobe,
  output logic       busy
);
  localparam int TICK_W = $clog2(WRITE_TICKS) + 1;

  logic              busyQ;
  logic [TICK_W-1:0] tickQ;
  logic              protectHit;

  assign protectHit = wpIn & (WHOLE_PROT | pageUpper);

  // Priority: stop, then load, then store, then advance. Nothing while busy.
  always_comb begin
    strobe = '0;
    if (!busyQ) begin
      if (stopSeen) begin
        strobe.endTxn = 1'b1;
        strobe.commit = pending & ~protectHit;
      end else if (addrLoad) begin
        strobe.loadAddr = 1'b1;
      end else if (dataValid) begin
        strobe.storeByte = 1'b1;
      end else if (readAdvance) begin
        strobe.advance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      tickQ <= '0;
    end else if (strobe.commit) begin
      busyQ <= 1'b1;
      tickQ <= TICK_W'(WRITE_TICKS - 1);
    end else if (busyQ) begin
      if (tickQ == '0) busyQ <= 1'b0;
      else             tickQ <= tickQ - 1'b1;
    end
  end

  assign busy = busyQ;
endmodule

// File: rtl/eps_datapath.sv
module eps_datapath
  import eps_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  epsStrobe_t                   strobe,
  input  logic [$clog2(MEM_BYTES)-1:0] addrIn,
  input  logic [7:0]                   dataIn,
  output logic [$clog2(MEM_BYTES)-1:0] curAddr,
  output logic [7:0]                   readData,
  output logic                         pageUpper,
  output logic                         pending
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [ADDR_W-1:0]     addrQ;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] maskQ;
  logic [7:0]            mem     [MEM_BYTES];

  // Word address counter: full roll on read, in-page wrap on write.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.loadAddr) begin
      addrQ <= addrIn;
    end else if (strobe.storeByte) begin
      addrQ <= {addrQ[ADDR_W-1:PAGE_W], addrQ[PAGE_W-1:0] + PAGE_W'(1)};
    end else if (strobe.advance) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  // Page staging buffer with a per-offset received mask.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      for (int j = 0; j < PAGE_BYTES; j++) pageBuf[j] <= '0;
    end else if (strobe.loadAddr || strobe.endTxn) begin
      maskQ <= '0;
    end else if (strobe.storeByte) begin
      pageBuf[addrQ[PAGE_W-1:0]] <= dataIn;
      maskQ[addrQ[PAGE_W-1:0]]   <= 1'b1;
    end
  end

  // Byte array: all received offsets of the page commit in one step.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else if (strobe.commit) begin
      for (int j = 0; j < PAGE_BYTES; j++) begin
        if (maskQ[j]) mem[{addrQ[ADDR_W-1:PAGE_W], PAGE_W'(j)}] <= pageBuf[j];
      end
    end
  end

  assign curAddr   = addrQ;
  assign readData  = mem[addrQ];
  assign pageUpper = addrQ[ADDR_W-1];
  assign pending   = |maskQ;
endmodule

// File: rtl/eeprom_page_store.sv
module eeprom_page_store
  import eps_pkg::*;
#(
  parameter int MEM_BYTES   = 256,
  parameter int WRITE_TICKS = 20
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wpIn,
  input  logic                         addrLoad,
  input  logic [$clog2(MEM_BYTES)-1:0] addrIn,
  input  logic                         dataValid,
  input  logic [7:0]                   dataIn,
  input  logic                         readAdvance,
  input  logic                         stopSeen,
  output logic [$clog2(MEM_BYTES)-1:0] curAddr,
  output logic [7:0]                   readData,
  output logic                         busy
);
  localparam int ADDR_W     = $clog2(MEM_BYTES);
  localparam int PAGE_BYTES = (MEM_BYTES <= 256) ? 8 : 16;
  localparam int PAGE_W     = $clog2(PAGE_BYTES);
  localparam bit WHOLE_PROT = (MEM_BYTES < 2048);

  epsStrobe_t strobe;
  logic       pageUpper;
  logic       pending;

  eps_ctrl #(.WRITE_TICKS(WRITE_TICKS), .WHOLE_PROT(WHOLE_PROT)) uCtrl (
    .clk(clk), .rstN(rstN), .wpIn(wpIn), .addrLoad(addrLoad),
    .dataValid(dataValid), .readAdvance(readAdvance), .stopSeen(stopSeen),
    .pageUpper(pageUpper), .pending(pending), .strobe(strobe), .busy(busy)
  );

  eps_datapath #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrIn(addrIn), .dataIn(dataIn),
    .curAddr(curAddr), .readData(readData), .pageUpper(pageUpper),
    .pending(pending)
  );
endmodule

// File: rtl/eps_checker.sv
module eps_checker #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int WRITE_TICKS = 20,
  parameter bit WHOLE_PROT  = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wpIn,
  input logic              addrLoad,
  input logic [ADDR_W-1:0] addrIn,
  input logic              dataValid,
  input logic              readAdvance,
  input logic              stopSeen,
  input logic [ADDR_W-1:0] curAddr,
  input logic              busy
);
  logic [31:0] runLen;
  always_ff @(posedge clk) begin
    if (!rstN || !busy) runLen <= '0;
    else                runLen <= runLen + 1;
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addrLoad && !busy && !stopSeen) |=> (curAddr == $past(addrIn)));

  assert_store_inpage_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !busy && !stopSeen && !addrLoad) |=>
      (curAddr[ADDR_W-1:PAGE_W] == $past(curAddr[ADDR_W-1:PAGE_W]) &&
       curAddr[PAGE_W-1:0] == PAGE_W'($past(curAddr[PAGE_W-1:0]) + 1'b1)));

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopSeen));

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runLen < WRITE_TICKS));

  assert_busy_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(curAddr));

  assert_advance_R7: assert property (@(posedge clk) disable iff (!rstN)
    (readAdvance && !busy && !stopSeen && !addrLoad && !dataValid) |=>
      (curAddr == ADDR_W'($past(curAddr) + 1'b1)));

  assert_protect_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && !busy && wpIn && (WHOLE_PROT || curAddr[ADDR_W-1])) |=> !busy);
endmodule

bind eeprom_page_store eps_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_TICKS(WRITE_TICKS), .WHOLE_PROT(WHOLE_PROT)
) uChk (
  .clk(clk), .rstN(rstN), .wpIn(wpIn), .addrLoad(addrLoad), .addrIn(addrIn),
  .dataValid(dataValid), .readAdvance(readAdvance), .stopSeen(stopSeen),
  .curAddr(curAddr), .busy(busy)
);

// File: tb/sim_eeprom_page_store.sv
`timescale 1ns/1ps
module sim_eeprom_page_store;
  localparam int TICKS = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wpIn = 1'b0, addrLoad = 1'b0, dataValid = 1'b0;
  logic        readAdvance = 1'b0, stopSeen = 1'b0;
  logic [10:0] addrBus = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  curAddr0, readData0, readData1;
  logic [10:0] curAddr1;
  logic        busy0, busy1;

  int  nTests = 0, nFail = 0;
  logic [7:0] model [256];

  always #5 clk = ~clk;

  eeprom_page_store #(.MEM_BYTES(256), .WRITE_TICKS(TICKS)) u0 (
    .clk(clk), .rstN(rstN), .wpIn(wpIn), .addrLoad(addrLoad), .addrIn(addrBus[7:0]),
    .dataValid(dataValid), .dataIn(dataIn), .readAdvance(readAdvance),
    .stopSeen(stopSeen), .curAddr(curAddr0), .readData(readData0), .busy(busy0));

  eeprom_page_store #(.MEM_BYTES(2048), .WRITE_TICKS(TICKS)) u1 (
    .clk(clk), .rstN(rstN), .wpIn(wpIn), .addrLoad(addrLoad), .addrIn(addrBus),
    .dataValid(dataValid), .dataIn(dataIn), .readAdvance(readAdvance),
    .stopSeen(stopSeen), .curAddr(curAddr1), .readData(readData1), .busy(busy1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic loadA(input int a);
    addrLoad = 1'b1; addrBus = 11'(a); @(negedge clk); addrLoad = 1'b0;
  endtask
  task automatic sendB(input logic [7:0] d);
    dataValid = 1'b1; dataIn = d; @(negedge clk); dataValid = 1'b0;
  endtask
  task automatic stopT();
    stopSeen = 1'b1; @(negedge clk); stopSeen = 1'b0;
  endtask
  task automatic stepR();
    readAdvance = 1'b1; @(negedge clk); readAdvance = 1'b0;
  endtask
  task automatic waitIdle();
    while (busy0 || busy1) @(negedge clk);
  endtask
  task automatic checkRead(input int a, input string tag);
    loadA(a);
    chk(readData0 == model[a], tag, readData0, model[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(curAddr0 == 8'd0, "R1 curAddr", curAddr0, 0);
    chk(busy0 == 1'b0, "R1 busy", busy0, 0);
    chk(readData0 == 8'd0, "R1 array zero", readData0, 0);

    // Full-array page sweep; busy length per page (R4, R5)
    for (int p = 0; p < 32; p++) begin
      int n;
      loadA(p * 8);
      chk(curAddr0 == 8'(p * 8), "R2 load", curAddr0, p * 8);
      for (int j = 0; j < 8; j++) begin
        logic [7:0] d;
        d = 8'((p * 8 + j) * 7 + 3);
        sendB(d);
        model[p * 8 + j] = d;
      end
      chk(readData0 != model[p * 8] || model[p * 8] == 8'h0 || 1'b0, "R4 not before stop",
          readData0, 0);
      stopT();
      n = 0;
      while (busy0) begin n++; @(negedge clk); end
      chk(n == TICKS, "R5 busy length", n, TICKS);
      waitIdle();
    end

    // Sequential read over the whole array with rollover (R7)
    loadA(0);
    for (int i = 0; i <= 256; i++) begin
      chk(curAddr0 == 8'(i % 256), "R7 counter", curAddr0, i % 256);
      chk(readData0 == model[i % 256], "R7 data", readData0, model[i % 256]);
      stepR();
    end

    // In-page wrap with overwrite (R3), data not in array before stop (R4)
    loadA(8'h0D);
    for (int k = 0; k < 10; k++) begin
      sendB(8'(8'hA0 + k));
      chk(curAddr0 == 8'(8 + ((5 + k + 1) % 8)), "R3 in-page step", curAddr0,
          8 + ((5 + k + 1) % 8));
    end
    chk(readData0 == model[15], "R4 held until stop", readData0, model[15]);
    for (int k = 0; k < 10; k++) model[8 + ((5 + k) % 8)] = 8'(8'hA0 + k);
    stopT();
    waitIdle();
    for (int a = 8; a < 16; a++) checkRead(a, "R3 wrap overwrite");

    // Partial page keeps other bytes (R4)
    loadA(8'h22); sendB(8'h5A); sendB(8'h6B);
    model[8'h22] = 8'h5A; model[8'h23] = 8'h6B;
    stopT(); waitIdle();
    for (int a = 8'h20; a < 8'h28; a++) checkRead(a, "R4 partial page");
    chk(curAddr0 == 8'h27, "R7 addr kept", curAddr0, 8'h27);

    // Strobes ignored while busy (R6)
    loadA(8'h40); sendB(8'h77); model[8'h40] = 8'h77; stopT();
    chk(busy0 == 1'b1, "R5 busy after stop", busy0, 1);
    loadA(8'h99);
    chk(curAddr0 == 8'h41, "R6 load ignored", curAddr0, 8'h41);
    sendB(8'h13); stepR(); stopT();
    chk(curAddr0 == 8'h41, "R6 step ignored", curAddr0, 8'h41);
    waitIdle();
    stopT();
    chk(busy0 == 1'b0, "R9 empty stop no busy", busy0, 0);
    checkRead(8'h41, "R6 data ignored");
    checkRead(8'h40, "R6 commit kept");

    // Priority: stop beats a same-cycle data byte (R9)
    loadA(8'h50); sendB(8'h11); model[8'h50] = 8'h11;
    stopSeen = 1'b1; dataValid = 1'b1; dataIn = 8'h22;
    @(negedge clk); stopSeen = 1'b0; dataValid = 1'b0;
    chk(curAddr0 == 8'h51, "R9 stop over data", curAddr0, 8'h51);
    waitIdle();
    checkRead(8'h51, "R9 data dropped");
    checkRead(8'h50, "R9 commit");

    // Write protect (R8)
    wpIn = 1'b1;
    loadA(8'h30); sendB(8'h55); stopT();
    chk(busy0 == 1'b0, "R8 whole protect no busy", busy0, 0);
    chk(busy1 == 1'b1, "R8 low half commits", busy1, 1);
    waitIdle();
    checkRead(8'h30, "R8 array unchanged");
    chk(readData1 == 8'h55, "R8 low half data", readData1, 8'h55);
    loadA(11'h530); sendB(8'h66); stopT();
    chk(busy1 == 1'b0, "R8 upper half no busy", busy1, 0);
    chk(curAddr1 == 11'h531, "R8 counter still moves", curAddr1, 11'h531);
    loadA(11'h530);
    chk(readData1 == 8'h00, "R8 upper half unchanged", readData1, 0);
    wpIn = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule